// File: doc/BRIEF.md
# Serial EEPROM Write-Guard and Status Controller

This block sits beside the command decoder of a serial EEPROM. It holds the status byte and the write-enable latch, and it decides whether a write to the storage array or to the status byte may go ahead. The decoder passes in single-cycle command strobes. Each strobe has a meaning: set the latch, clear the latch, load new status fields, or request an array write at a given address. The chip-select and write-protect pins also come in. The block answers with the byte that a status read returns, with two permission flags, with a busy flag, and with a one-clock commit pulse that tells the array when a granted write has finished.

An accepted write request is held while the device is selected. The self-timed cycle starts on the clock after chip-select returns high and lasts a fixed, parameterised number of clocks. The new protection settings appear only when that cycle ends, and the write-enable latch clears itself at the same time. Block protection always covers the top of the address space: a quarter, a half or all of it. The boundaries come from the address-width parameter. The protect pin matters only while the stored pin-enable bit is set.

Top module: `eeprom_protect_ctrl`

## Requirements
- R1: After synchronous reset the status byte reads 0x00, busy is low, and both permission flags are low.
- R2: While idle, the status byte reads bit 7 = pin-enable, bits 3:2 = protect level, bit 1 = write-enable latch, and bits 6:4 and bit 0 = 0.
- R3: While a write cycle is running, the status byte reads 0xFF.
- R4: A set-latch strobe sets the write-enable latch and a clear-latch strobe clears it, whatever the protect pin does. Strobes given while cs_n is high have no effect, and no write cycle can start while the latch is clear.
- R5: Protect level 0 guards nothing. Level 1 guards addresses whose two top bits are 11. Level 2 guards addresses whose top bit is 1. Level 3 guards every address. arr_wr_ok is high only when the latch is set, the address in arr_addr is unguarded, and no cycle is running.
- R6: While wp_n is low and pin-enable is 1, sr_wr_ok is low and a status load request is refused, so pin-enable cannot be cleared.
- R7: While pin-enable is 0, wp_n has no effect. Array writes to unguarded addresses are allowed whatever the pin and pin-enable state.
- R8: An accepted status load is cancelled if wp_n goes low (with pin-enable = 1) before cs_n rises. No cycle then starts.
- R9: An accepted request starts a cycle in the clock after cs_n rises. busy then stays high for exactly WR_CYCLES clocks, and new status fields become visible only after it ends.
- R10: The write-enable latch is clear once any write cycle ends.
- R11: While busy, all command strobes are ignored.
- R12: An array write that was granted drives arr_commit high for the last busy clock, with commit_addr equal to the requested address. A request to a guarded address starts no cycle.
- R13: Once a status cycle has started, wp_n going low does not stop it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_wren | input | 1 | Strobe: set write-enable latch |
| cmd_wrdi | input | 1 | Strobe: clear write-enable latch |
| cmd_wrsr | input | 1 | Strobe: load new status fields |
| sr_new_wpen | input | 1 | Requested pin-enable value |
| sr_new_bp | input | 2 | Requested protect level |
| arr_req | input | 1 | Strobe: request array write |
| arr_addr | input | ADDR_W | Array address for permission and request |
| status | output | 8 | Status byte as returned to a read |
| busy | output | 1 | Write cycle running |
| sr_wr_ok | output | 1 | A status load would be accepted now |
| arr_wr_ok | output | 1 | A write to arr_addr would be accepted now |
| arr_commit | output | 1 | Last clock of a granted array write cycle |
| commit_addr | output | ADDR_W | Address being committed |

## Verification
The bench attacks the protection boundaries at each level: the last unguarded address and the first guarded one. A design with an off-by-one range would grant or refuse the wrong side. It drops the protect pin while a status load is pending, and again after the cycle has begun. A design that does not cancel the first would lock in the new settings, and one that aborts the second would lose them. It also issues strobes during a running cycle and checks the exact busy length, which exposes a latch that stays set, status fields that update early, or a cycle counter that is one clock short or long.

// File: rtl/eprot_pkg.sv
// Package: shared types and helpers for the write-guard controller.
// Assumes a status byte layout fixed by the read path that consumes it.
package eprot_pkg;

    typedef enum logic {
        OP_ARRAY  = 1'b0,
        OP_STATUS = 1'b1
    } wr_op_e;

    typedef struct packed {
        logic       wpen;
        logic [1:0] bp;
        logic       wen;
    } guard_state_t;

    // Build the byte a status read returns.
    function automatic logic [7:0] pack_status(guard_state_t s, logic running);
        if (running) begin
            return 8'hFF;
        end
        return {s.wpen, 3'b000, s.bp, s.wen, 1'b0};
    endfunction

endpackage

// File: rtl/eprot_range.sv
// Module: decides whether an address lies in the guarded top region.
// Assumes ADDR_W >= 2; boundaries derive from ADDR_W only.
module eprot_range #(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        level,
    output logic              guarded
);
    localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);
    localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(3) << (ADDR_W - 2);

    // Compare against the level's lower boundary.
    always_comb begin
        unique case (level)
            2'b00:   guarded = 1'b0;
            2'b01:   guarded = (addr >= QTR_BASE);
            2'b10:   guarded = (addr >= HALF_BASE);
            default: guarded = 1'b1;
        endcase
    end
endmodule

// File: rtl/eprot_timer.sv
// Module: self-timed write cycle; busy for exactly CYCLES clocks after start.
// Assumes start is ignored while already running.
module eprot_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic running,
    output logic last
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    // Count down the remaining clocks of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            remain  <= '0;
        end else if (start && !running) begin
            running <= 1'b1;
            remain  <= CW'(CYCLES - 1);
        end else if (running) begin
            if (remain == '0) begin
                running <= 1'b0;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end

    assign last = running && (remain == '0);
endmodule

// File: rtl/eprot_status.sv
// Module: holds the write-enable latch and the stored protection fields.
// Assumes clear has priority over set for the latch.
module eprot_status
    import eprot_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_wen,
    input  logic         clr_wen,
    input  logic         load,
    input  logic         load_wpen,
    input  logic [1:0]   load_bp,
    output guard_state_t st
);
    // Latch update: clear wins over set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st.wen <= 1'b0;
        end else if (clr_wen) begin
            st.wen <= 1'b0;
        end else if (set_wen) begin
            st.wen <= 1'b1;
        end
    end

    // Protection fields change only at the end of a status cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st.wpen <= 1'b0;
            st.bp   <= 2'b00;
        end else if (load) begin
            st.wpen <= load_wpen;
            st.bp   <= load_bp;
        end
    end
endmodule

// File: rtl/eeprom_protect_ctrl.sv
// Module: write-guard and status controller for a serial EEPROM.
// Takes decoded command strobes, holds accepted requests until chip select
// rises, runs the timed cycle and reports status and permissions.
// Assumes at most one command strobe per clock.
module eeprom_protect_ctrl
    import eprot_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int WR_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic              sr_new_wpen,
    input  logic [1:0]        sr_new_bp,
    input  logic              arr_req,
    input  logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        status,
    output logic              busy,
    output logic              sr_wr_ok,
    output logic              arr_wr_ok,
    output logic              arr_commit,
    output logic [ADDR_W-1:0] commit_addr
);
    guard_state_t      st;
    logic              cs_n_q;
    logic              cs_rise;
    logic              accept;
    logic              hw_lock;
    logic              addr_guarded;
    logic              pend_sr;
    logic              pend_arr;
    logic              pend_wpen;
    logic [1:0]        pend_bp;
    logic [ADDR_W-1:0] pend_addr;
    wr_op_e            op_q;
    logic              start_sr;
    logic              start_arr;
    logic              cyc_last;

    assign cs_rise = cs_n && !cs_n_q;
    assign accept  = !cs_n && !busy;
    assign hw_lock = st.wpen && !wp_n;

    assign sr_wr_ok  = st.wen && !hw_lock && !busy;
    assign arr_wr_ok = st.wen && !addr_guarded && !busy;

    assign start_sr  = cs_rise && pend_sr && st.wen && !hw_lock;
    assign start_arr = cs_rise && pend_arr && st.wen && !pend_sr;

    eprot_range #(.ADDR_W(ADDR_W)) range_i (
        .addr    (arr_addr),
        .level   (st.bp),
        .guarded (addr_guarded)
    );

    eprot_timer #(.CYCLES(WR_CYCLES)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_sr || start_arr),
        .running (busy),
        .last    (cyc_last)
    );

    eprot_status status_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_wen   (accept && cmd_wren),
        .clr_wen   ((accept && cmd_wrdi) || cyc_last),
        .load      (cyc_last && (op_q == OP_STATUS)),
        .load_wpen (pend_wpen),
        .load_bp   (pend_bp),
        .st        (st)
    );

    // Track chip select to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_q <= 1'b1;
        end else begin
            cs_n_q <= cs_n;
        end
    end

    // Hold accepted requests until deselect; cancel a status load on lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_sr   <= 1'b0;
            pend_arr  <= 1'b0;
            pend_wpen <= 1'b0;
            pend_bp   <= 2'b00;
            pend_addr <= '0;
        end else if (cs_rise) begin
            pend_sr  <= 1'b0;
            pend_arr <= 1'b0;
        end else begin
            if (pend_sr && hw_lock) begin
                pend_sr <= 1'b0;
            end
            if (accept && cmd_wrsr && sr_wr_ok) begin
                pend_sr   <= 1'b1;
                pend_arr  <= 1'b0;
                pend_wpen <= sr_new_wpen;
                pend_bp   <= sr_new_bp;
            end else if (accept && arr_req && arr_wr_ok) begin
                pend_arr  <= 1'b1;
                pend_sr   <= 1'b0;
                pend_addr <= arr_addr;
            end
        end
    end

    // Remember which kind of cycle is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= OP_ARRAY;
        end else if (start_sr) begin
            op_q <= OP_STATUS;
        end else if (start_arr) begin
            op_q <= OP_ARRAY;
        end
    end

    assign status      = pack_status(st, busy);
    assign arr_commit  = cyc_last && (op_q == OP_ARRAY);
    assign commit_addr = pend_addr;
endmodule

// File: rtl/eprot_checker.sv
// Checker: temporal properties of the write-guard controller, seen at its ports.
// Assumes it is bound to every instance of eeprom_protect_ctrl.
module eprot_checker #(
    parameter int WR_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       wp_n,
    input logic [7:0] status,
    input logic       busy,
    input logic       sr_wr_ok,
    input logic       arr_wr_ok,
    input logic       arr_commit
);
    int unsigned run_len;

    // Length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= 0;
        end else if (busy) begin
            run_len <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    assert_ff_when_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (status == 8'hFF));

    assert_idle_zero_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (status[6:4] == 3'b000 && !status[0]));

    assert_pin_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && status[7] && !wp_n) |-> !sr_wr_ok);

    assert_array_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_ok |-> (!busy && status[1] && status[3:2] != 2'b11));

    assert_start_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> cs_n);

    assert_start_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(status[1]));

    assert_latch_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !status[1]);

    assert_busy_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == WR_CYCLES));

    assert_commit_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
        arr_commit |-> (busy && !sr_wr_ok) ##1 !busy);
endmodule

bind eeprom_protect_ctrl eprot_checker #(.WR_CYCLES(WR_CYCLES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .wp_n       (wp_n),
    .status     (status),
    .busy       (busy),
    .sr_wr_ok   (sr_wr_ok),
    .arr_wr_ok  (arr_wr_ok),
    .arr_commit (arr_commit)
);

// File: tb/eeprom_protect_ctrl_tb_top.sv
`timescale 1ns/1ps
module eeprom_protect_ctrl_tb_top;
    localparam int AW = 10;
    localparam int WR = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          wp_n = 1'b1;
    logic          cmd_wren = 1'b0;
    logic          cmd_wrdi = 1'b0;
    logic          cmd_wrsr = 1'b0;
    logic          sr_new_wpen = 1'b0;
    logic [1:0]    sr_new_bp = 2'b00;
    logic          arr_req = 1'b0;
    logic [AW-1:0] arr_addr = '0;
    logic [7:0]    status;
    logic          busy;
    logic          sr_wr_ok;
    logic          arr_wr_ok;
    logic          arr_commit;
    logic [AW-1:0] commit_addr;

    int n_checks = 0;
    int n_err = 0;
    int n_commit = 0;
    int last_caddr = 0;
    int bcount = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    eeprom_protect_ctrl #(.ADDR_W(AW), .WR_CYCLES(WR)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
        .sr_new_wpen(sr_new_wpen), .sr_new_bp(sr_new_bp),
        .arr_req(arr_req), .arr_addr(arr_addr),
        .status(status), .busy(busy), .sr_wr_ok(sr_wr_ok),
        .arr_wr_ok(arr_wr_ok), .arr_commit(arr_commit), .commit_addr(commit_addr)
    );

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_rem, m_bp, m_pbp, m_paddr;
    bit m_wen, m_wpen, m_psr, m_parr, m_pw, m_op_sr, m_csq;
    bit t_rise, t_hw, t_owen;

    function automatic bit m_guard(int a, int lvl);
        int size = 1 << AW;
        if (lvl == 0) return 0;
        if (lvl == 1) return a >= (size / 4) * 3;
        if (lvl == 2) return a >= size / 2;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rem = 0; m_bp = 0; m_pbp = 0; m_paddr = 0;
            m_wen = 0; m_wpen = 0; m_psr = 0; m_parr = 0; m_pw = 0;
            m_op_sr = 0; m_csq = 1;
        end else begin
            t_rise = cs_n && !m_csq;
            t_hw   = m_wpen && !wp_n;
            t_owen = m_wen;
            if (m_rem > 0) begin
                if (m_rem == 1) begin
                    if (m_op_sr) begin
                        m_wpen = m_pw;
                        m_bp   = m_pbp;
                    end
                    m_wen = 0;
                end
                m_rem--;
            end else if (t_rise) begin
                if (m_psr && t_owen && !t_hw) begin
                    m_rem = WR; m_op_sr = 1;
                end else if (m_parr && t_owen) begin
                    m_rem = WR; m_op_sr = 0;
                end
                m_psr = 0; m_parr = 0;
            end else begin
                if (m_psr && t_hw) m_psr = 0;
                if (!cs_n) begin
                    if (cmd_wrsr && t_owen && !t_hw) begin
                        m_psr = 1; m_parr = 0; m_pw = sr_new_wpen; m_pbp = sr_new_bp;
                    end else if (arr_req && t_owen && !m_guard(arr_addr, m_bp)) begin
                        m_parr = 1; m_psr = 0; m_paddr = arr_addr;
                    end
                    if (cmd_wren) m_wen = 1;
                    if (cmd_wrdi) m_wen = 0;
                end
            end
            m_csq = cs_n;
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            automatic bit eb = (m_rem > 0);
            automatic int es = eb ? 8'hFF : ((m_wpen << 7) | (m_bp << 2) | (m_wen << 1));
            chk(eb ? "R3 status" : "R2 status", status, es);
            chk("R9 busy", busy, eb);
            chk("R6 sr_wr_ok", sr_wr_ok, m_wen && !(m_wpen && !wp_n) && !eb);
            chk("R5 arr_wr_ok", arr_wr_ok, m_wen && !m_guard(arr_addr, m_bp) && !eb);
            chk("R12 arr_commit", arr_commit, (m_rem == 1) && !m_op_sr);
            if (arr_commit) begin
                n_commit++;
                last_caddr = commit_addr;
            end
            if (busy) bcount++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic sel();
        @(negedge clk); #1 cs_n = 1'b0;
    endtask
    task automatic desel();
        @(negedge clk); #1 cs_n = 1'b1;
    endtask
    task automatic s_wren();
        @(negedge clk); #1 cmd_wren = 1'b1;
        @(negedge clk); #1 cmd_wren = 1'b0;
    endtask
    task automatic s_wrdi();
        @(negedge clk); #1 cmd_wrdi = 1'b1;
        @(negedge clk); #1 cmd_wrdi = 1'b0;
    endtask
    task automatic s_wrsr(bit w, logic [1:0] lvl);
        @(negedge clk); #1 cmd_wrsr = 1'b1; sr_new_wpen = w; sr_new_bp = lvl;
        @(negedge clk); #1 cmd_wrsr = 1'b0;
    endtask
    task automatic s_arr(int a);
        @(negedge clk); #1 arr_req = 1'b1; arr_addr = AW'(a);
        @(negedge clk); #1 arr_req = 1'b0;
    endtask
    task automatic wren_txn();
        sel(); s_wren(); desel();
    endtask
    task automatic set_addr(int a);
        @(negedge clk); #1 arr_addr = AW'(a);
    endtask
    task automatic status_write(bit w, logic [1:0] lvl);
        wren_txn(); sel(); s_wrsr(w, lvl); desel(); cyc(WR + 3);
    endtask

    initial begin
        cyc(5);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset status", status, 8'h00);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset sr_wr_ok", sr_wr_ok, 0);

        // R4: strobe while deselected is ignored.
        @(negedge clk); #1 cmd_wren = 1'b1;
        @(negedge clk); #1 cmd_wren = 1'b0;
        @(negedge clk);
        chk("R4 deselected strobe", status, 8'h00);

        // R4: status load without latch starts nothing.
        sel(); s_wrsr(1'b1, 2'b01); desel(); cyc(3);
        chk("R4 no cycle without latch", busy, 0);

        // R4: set, then clear with protect pin low.
        wren_txn(); @(negedge clk);
        chk("R4 latch set", status, 8'h02);
        #1 wp_n = 1'b0;
        sel(); s_wrdi(); desel(); @(negedge clk);
        chk("R4 latch clear with pin low", status, 8'h00);
        #1 wp_n = 1'b1;

        // R3/R9/R10/R11: status cycle with strobes during busy.
        wren_txn(); sel(); s_wrsr(1'b1, 2'b01);
        @(negedge clk); bcount = 0; #1 cs_n = 1'b1;
        @(negedge clk);
        chk("R3 busy reads all ones", status, 8'hFF);
        sel(); s_wren(); desel();
        cyc(WR + 2);
        chk("R9 busy length", bcount, WR);
        chk("R10 R11 R2 status after cycle", status, 8'h84);

        // R5/R6/R7 with level 1 and pin enable set.
        wren_txn(); set_addr(10'h2FF); @(negedge clk);
        chk("R5 last free addr level1", arr_wr_ok, 1);
        set_addr(10'h300); @(negedge clk);
        chk("R5 first guarded addr level1", arr_wr_ok, 0);
        #1 wp_n = 1'b0; arr_addr = 10'h100;
        @(negedge clk);
        chk("R7 array free under pin lock", arr_wr_ok, 1);
        chk("R6 sr_wr_ok locked", sr_wr_ok, 0);
        sel(); s_wrsr(1'b0, 2'b00); desel(); cyc(3);
        chk("R6 refused load busy", busy, 0);
        chk("R6 pin enable kept", status, 8'h86);

        // R8: pin drops while load is pending.
        #1 wp_n = 1'b1;
        sel(); s_wrsr(1'b1, 2'b10);
        @(negedge clk); #1 wp_n = 1'b0;
        desel(); cyc(3);
        chk("R8 cancelled load", busy, 0);
        chk("R8 status unchanged", status, 8'h86);
        #1 wp_n = 1'b1;

        // R13: pin drops after the cycle has started.
        sel(); s_wrsr(1'b1, 2'b10); desel();
        @(negedge clk);
        chk("R13 cycle started", busy, 1);
        #1 wp_n = 1'b0;
        cyc(WR + 2);
        chk("R13 load completed", status, 8'h88);
        #1 wp_n = 1'b1;

        // R5 level 2 and R12 array write.
        wren_txn(); set_addr(10'h1FF); @(negedge clk);
        chk("R5 last free addr level2", arr_wr_ok, 1);
        set_addr(10'h200); @(negedge clk);
        chk("R5 first guarded addr level2", arr_wr_ok, 0);
        n_commit = 0;
        sel(); s_arr(10'h155); desel(); cyc(WR + 3);
        chk("R12 one commit", n_commit, 1);
        chk("R12 commit address", last_caddr, 10'h155);
        chk("R10 latch cleared after array write", status, 8'h88);

        // R12: guarded request starts nothing.
        wren_txn(); sel(); s_arr(10'h3F0); desel(); cyc(3);
        chk("R12 guarded no cycle", busy, 0);
        chk("R12 latch still set", status, 8'h8A);

        // Level 3 with pin enable cleared; R7 pin ignored.
        status_write(1'b0, 2'b11);
        chk("R2 level3 status", status, 8'h0C);
        wren_txn(); set_addr(0); @(negedge clk);
        chk("R5 level3 guards zero", arr_wr_ok, 0);
        #1 wp_n = 1'b0;
        @(negedge clk);
        chk("R7 pin ignored without enable", sr_wr_ok, 1);
        sel(); s_wrsr(1'b0, 2'b00); desel(); cyc(WR + 3);
        chk("R7 load under pin low", status, 8'h00);
        #1 wp_n = 1'b1;
        wren_txn(); set_addr(10'h3FF); @(negedge clk);
        chk("R5 level0 top free", arr_wr_ok, 1);

        cyc(2);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule